// File: doc/BRIEF.md
# Timer Time Base with Center-Aligned Counting

This block is the counting core of a general-purpose timer. A counter steps once per clock while it is running and turns at a programmable reload limit. In edge mode it counts in a single direction chosen by software. In the three center modes it ramps up to the limit and back down to zero, over and over. Each wrap or turn is an update event. An update event can reload a buffered copy of the limit, raise a one-cycle update request and, in one-shot mode, stop the counter.

Software controls the block through a small write/read register bus with four word addresses. Address 0 is the control word. Address 1 is the reload limit. Address 2 is the compare value. Address 3 is an event/flag word: writing bit 0 forces an update, writing 1 to bit 1 clears the compare flag, and bit 1 reads back that flag. A slave-mode pulse input forces an update in the same way as the software bit. A free-running divider gives a sampling enable for dead-time logic further along the chip.

Top module: `tmr_timebase`

## Requirements
- R1: After reset, every bus word reads 0, and the counter, the update request and the compare flag are all 0.
- R2: The control word at address 0 holds: bit 0 run, bit 1 update-off, bit 2 counter-only source, bit 3 one-shot, bit 4 down, bits 6:5 alignment code, bit 7 reload buffering, bits 9:8 divider code. It reads back as written. Bits above 9 read 0.
- R3: With alignment code 0 and down=0, the counter goes 0,1,…,L,0 for a limit L. The update request is high for the one cycle in which the counter shows 0 after L.
- R4: With alignment code 0 and down=1, the counter goes from 0 to L and then counts down to 0. The request is high in the cycle that follows each reload to L.
- R5: With alignment code 1, 2 or 3, the counter goes 0…L and back to 0, turning at L and at 0. Bit 4 reads back the current direction. Software writes to bit 4 are ignored while the held alignment code is nonzero. Both turns raise a request.
- R6: The compare flag is set one cycle after a running counter equals the compare value. Code 1 allows this only while counting down, code 2 only while counting up, and codes 0 and 3 in either direction. The flag stays set until a 1 is written to address 3 bit 1.
- R7: With update-off set, no update request is raised and the buffered limit is not moved into the active limit. The counter still wraps.
- R8: With counter-only source clear, a software force (address 3 bit 0) or a slave pulse raises the request one cycle later. With it set, only a counter wrap or turn raises a request.
- R9: In one-shot mode the run bit clears itself at the first update event, and the counter then holds its value.
- R10: With buffering off, a limit write takes effect at once. With buffering on, the new limit takes effect only from the next update event.
- R11: The dead-time enable is high on 1 of every 1, 2 or 4 cycles for divider codes 0, 1 and 2. Code 3 behaves like code 2.
- R12: A software force or slave pulse loads the counter with 0 when counting up, or with the limit (after any reload) when counting down, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| slv_upd | input | 1 | Slave-mode update pulse |
| upd_req | output | 1 | One-cycle update interrupt / DMA request |
| cmp_flag | output | 1 | Sticky compare flag |
| cnt_val | output | 16 | Current counter value |
| dts_en | output | 1 | Dead-time sampling clock enable |

## Verification
A wrong direction state in a center mode shows up within one step. The counter climbs past the limit or drops below zero instead of turning, and the direction bit read at address 0 disagrees with the triangle computed in the bench. A stale active limit changes the wrap point in the very next period. A mishandled run bit or update gate shows at the request port on the cycle right after the event. A wrong direction filter leaves the compare flag low, or sets it a half-period early, at the sampled points of the triangle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W  = 10;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTL    = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_EVT    = 2'd3;

  typedef enum logic [1:0] {
    ALN_EDGE  = 2'd0,
    ALN_CDOWN = 2'd1,
    ALN_CUP   = 2'd2,
    ALN_CBOTH = 2'd3
  } align_e;

  // field order fixes the software-visible bit positions
  typedef struct packed {
    logic [1:0] ckdiv;
    logic       shadow_en;
    align_e     align;
    logic       down;
    logic       one_shot;
    logic       hw_only;
    logic       upd_off;
    logic       run;
  } ctl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              upd_evt,
  input  logic              stop_req,
  input  logic              dir_hw_we,
  input  logic              dir_hw_val,
  output ctl_t              ctl,
  output logic [CNT_W-1:0]  reload_pre,
  output logic [CNT_W-1:0]  reload_act,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              ug_pulse,
  output logic              flag_clr
);
  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] pre_q, pre_d, act_q, act_d, cmp_q, cmp_d;
  logic             wr_ctl, wr_rld, wr_cmp, wr_evt;

  always_comb begin
    wr_ctl   = we && (addr == ADDR_CTL);
    wr_rld   = we && (addr == ADDR_RELOAD);
    wr_cmp   = we && (addr == ADDR_CMP);
    wr_evt   = we && (addr == ADDR_EVT);
    ug_pulse = wr_evt && wdata[0];
    flag_clr = wr_evt && wdata[1];
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d = ctl_t'(wdata[CTL_W-1:0]);
      // direction belongs to hardware while a center mode is held
      if (ctl_q.align != ALN_EDGE) ctl_d.down = ctl_q.down;
    end
    if (dir_hw_we) ctl_d.down = dir_hw_val;
    if (stop_req)  ctl_d.run  = 1'b0;
  end

  always_comb begin
    pre_d = pre_q;
    act_d = act_q;
    cmp_d = cmp_q;
    if (upd_evt) act_d = pre_q;
    if (wr_rld) begin
      pre_d = wdata;
      if (!ctl_q.shadow_en) act_d = wdata;
    end
    if (wr_cmp) cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      pre_q <= '0;
      act_q <= '0;
      cmp_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      pre_q <= pre_d;
      act_q <= act_d;
      cmp_q <= cmp_d;
    end
  end

  assign ctl        = ctl_q;
  assign reload_pre = pre_q;
  assign reload_act = act_q;
  assign cmp_val    = cmp_q;
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  align_e           align,
  input  logic             down,
  input  logic [CNT_W-1:0] limit,
  input  logic             reinit,
  input  logic [CNT_W-1:0] reinit_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt,
  output logic             dir_hw_we,
  output logic             dir_hw_val
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, step;
  logic             center, at_top, at_bot, turn;

  always_comb begin
    center = (align != ALN_EDGE);
    at_top = (cnt_q >= limit);
    at_bot = (cnt_q == '0);
    if (!down) begin
      turn = at_top;
      if (!at_top)         step = cnt_q + ONE;
      else if (!center)    step = '0;
      else if (limit == 0) step = '0;
      else                 step = limit - ONE;
    end else begin
      turn = at_bot;
      if (!at_bot)         step = cnt_q - ONE;
      else if (!center)    step = limit;
      else if (limit == 0) step = '0;
      else                 step = ONE;
    end
    wrap_evt   = run && turn;
    dir_hw_we  = run && turn && center;
    dir_hw_val = ~down;
    if (reinit)   cnt_d = reinit_val;
    else if (run) cnt_d = step;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_val,
  input  align_e           align,
  input  logic             down,
  input  logic             clr,
  output logic             flag
);
  logic dir_ok, hit, flag_q, flag_d;

  always_comb begin
    unique case (align)
      ALN_CDOWN: dir_ok = down;
      ALN_CUP:   dir_ok = ~down;
      default:   dir_ok = 1'b1;
    endcase
    hit = run && (cnt == cmp_val) && dir_ok;
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/tmr_dts.sv
module tmr_dts #(
  parameter int DIV_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ckdiv,
  output logic       dts_en
);
  logic [DIV_W-1:0] div_q, div_d, mask;

  always_comb begin
    div_d = div_q + 1'b1;
    unique case (ckdiv)
      2'd0:    mask = '0;
      2'd1:    mask = DIV_W'(1);
      default: mask = DIV_W'(3);
    endcase
    dts_en = ((div_q & mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slv_upd,
  output logic              upd_req,
  output logic              cmp_flag,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              dts_en
);
  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  ctl_t             ctl;
  logic [CNT_W-1:0] reload_pre, reload_act, cmp_val, reinit_val;
  logic             ug_pulse, flag_clr, wrap_evt, dir_hw_we, dir_hw_val;
  logic             force_upd, upd_evt, stop_req, req_d, req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  always_comb begin
    force_upd  = ug_pulse | slv_upd;
    upd_evt    = ~ctl.upd_off & (wrap_evt | force_upd);
    stop_req   = upd_evt & ctl.one_shot;
    req_d      = upd_evt & (~ctl.hw_only | wrap_evt);
    reinit_val = !ctl.down ? '0 : (upd_evt ? reload_pre : reload_act);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) req_q <= 1'b0;
    else             req_q <= req_d;
  end
  assign upd_req = req_q;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we         (bus_we),
    .addr       (bus_addr),
    .wdata      (bus_wdata[CNT_W-1:0]),
    .upd_evt    (upd_evt),
    .stop_req   (stop_req),
    .dir_hw_we  (dir_hw_we),
    .dir_hw_val (dir_hw_val),
    .ctl        (ctl),
    .reload_pre (reload_pre),
    .reload_act (reload_act),
    .cmp_val    (cmp_val),
    .ug_pulse   (ug_pulse),
    .flag_clr   (flag_clr)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (ctl.run),
    .align      (ctl.align),
    .down       (ctl.down),
    .limit      (reload_act),
    .reinit     (force_upd),
    .reinit_val (reinit_val),
    .cnt        (cnt_val),
    .wrap_evt   (wrap_evt),
    .dir_hw_we  (dir_hw_we),
    .dir_hw_val (dir_hw_val)
  );

  tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (ctl.run),
    .cnt     (cnt_val),
    .cmp_val (cmp_val),
    .align   (ctl.align),
    .down    (ctl.down),
    .clr     (flag_clr),
    .flag    (cmp_flag)
  );

  tmr_dts #(.DIV_W(2)) u_dts (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ckdiv  (ctl.ckdiv),
    .dts_en (dts_en)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTL:    bus_rdata[CTL_W-1:0] = ctl;
      ADDR_RELOAD: bus_rdata[CNT_W-1:0] = reload_pre;
      ADDR_CMP:    bus_rdata[CNT_W-1:0] = cmp_val;
      default:     bus_rdata[1]         = cmp_flag;
    endcase
  end
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input ctl_t             ctl,
  input logic             upd_req,
  input logic             upd_evt,
  input logic             wrap_evt,
  input logic             force_upd,
  input logic             flag_clr,
  input logic             cmp_flag,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] reload_act
);
  // R7
  updoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.upd_off |=> !upd_req);

  // R8
  hwonly_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.hw_only && !wrap_evt) |=> !upd_req);

  // R9
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && ctl.one_shot) |=> !ctl.run);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !flag_clr) |=> cmp_flag);

  // R6
  down_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_flag && ctl.align == ALN_CDOWN && !ctl.down) |=> !cmp_flag);

  // R3
  edge_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && ctl.align == ALN_EDGE && !ctl.down && !force_upd
     && cnt_val == reload_act) |=> (cnt_val == '0));
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ctl        (ctl),
  .upd_req    (upd_req),
  .upd_evt    (upd_evt),
  .wrap_evt   (wrap_evt),
  .force_upd  (force_upd),
  .flag_clr   (flag_clr),
  .cmp_flag   (cmp_flag),
  .cnt_val    (cnt_val),
  .reload_act (reload_act)
);

// File: tb/test_tmr_timebase.sv
module test_tmr_timebase;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        slv_upd = 1'b0;
  logic        upd_req, cmp_flag, dts_en;
  logic [15:0] cnt_val;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_timebase i_tmr_timebase (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slv_upd(slv_upd),
    .upd_req(upd_req), .cmp_flag(cmp_flag), .cnt_val(cnt_val), .dts_en(dts_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 2'd0; #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_slave();
    @(negedge clk); slv_upd = 1'b1;
    @(negedge clk); slv_upd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv); chk("R1 word", int'(rv), 0);
    end
    chk("R1 cnt", int'(cnt_val), 0);
    chk("R1 req", int'(upd_req), 0);
    chk("R1 flag", int'(cmp_flag), 0);

    // R2 field readback, upper bits dropped
    wr(0, 32'hFFFF_FD9E);
    rd(0, rv); chk("R2 readback", int'(rv), 'h19E);
    wr(0, 32'h0000_0000);
    // R5 direction write ignored in center mode
    wr(0, 32'h40);
    wr(0, 32'h50);
    rd(0, rv); chk("R5 dir ignored", int'(rv), 'h40);

    // R3 edge up sweep
    for (int n = 1; n <= 6; n++) begin
      do_reset(); wr(1, n); wr(0, 32'h01);
      for (int k = 0; k < 3*(n+1); k++) begin
        chk("R3 cnt", int'(cnt_val), k % (n+1));
        chk("R3 req", int'(upd_req), int'(k > 0 && k % (n+1) == 0));
        @(negedge clk);
      end
    end
    // R4 edge down sweep
    for (int n = 1; n <= 6; n++) begin
      do_reset(); wr(1, n); wr(0, 32'h11);
      for (int k = 0; k < 3*(n+1); k++) begin
        chk("R4 cnt", int'(cnt_val), ((n+1) - k % (n+1)) % (n+1));
        chk("R4 req", int'(upd_req), int'(k % (n+1) == 1));
        @(negedge clk);
      end
    end
    // R5 center sweep (code 3)
    for (int n = 2; n <= 6; n++) begin
      do_reset(); wr(1, n); wr(0, 32'h61);
      for (int k = 0; k < 6*n; k++) begin
        int m;
        m = k % (2*n);
        chk("R5 cnt", int'(cnt_val), (m <= n) ? m : 2*n - m);
        chk("R5 dir", int'(bus_rdata[4]), int'(m >= n+1 || (m == 0 && k > 0)));
        chk("R5 req", int'(upd_req), int'(m == n+1 || (m == 1 && k > 1)));
        @(negedge clk);
      end
    end

    // R6 compare filter per alignment code, limit 6, compare 3
    for (int code = 0; code < 4; code++) begin
      do_reset(); wr(1, 6); wr(2, 3); wr(0, 32'h01 | (code << 5));
      for (int k = 0; k < 12; k++) begin
        if (k == 5 || k == 8) chk("R6 flag early", int'(cmp_flag), int'(code != 1));
        if (k == 11)          chk("R6 flag late", int'(cmp_flag), 1);
        @(negedge clk);
      end
      wr(0, 32'h0);
      chk("R6 sticky", int'(cmp_flag), 1);
      wr(3, 32'h2);
      chk("R6 cleared", int'(cmp_flag), 0);
    end

    // R7 update-off with buffering on; R10 buffered reload
    begin
      int mx; bit seen_wrap, seen_req, seen_six; int prev;
      do_reset(); wr(1, 3); wr(0, 32'h83); wr(1, 6);
      mx = 0; seen_wrap = 0; seen_req = 0; prev = int'(cnt_val);
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (int'(cnt_val) > mx) mx = int'(cnt_val);
        if (prev == 3 && cnt_val == 0) seen_wrap = 1;
        if (upd_req) seen_req = 1;
        prev = int'(cnt_val);
      end
      chk("R7 limit kept", mx, 3);
      chk("R7 wrapped", int'(seen_wrap), 1);
      chk("R7 no req", int'(seen_req), 0);
      rd(1, rv); chk("R10 pre value", int'(rv), 6);
      wr(0, 32'h81);
      seen_six = 0; seen_req = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (cnt_val == 6) seen_six = 1;
        if (upd_req) seen_req = 1;
      end
      chk("R10 buffered limit used", int'(seen_six), 1);
      chk("R7 req resumes", int'(seen_req), 1);
    end

    // R10 immediate limit without buffering
    begin
      int mx;
      do_reset(); wr(1, 9); wr(0, 32'h01);
      repeat (2) @(negedge clk);
      wr(1, 2);
      @(negedge clk);
      mx = 0;
      for (int k = 0; k < 12; k++) begin
        if (int'(cnt_val) > mx) mx = int'(cnt_val);
        @(negedge clk);
      end
      chk("R10 immediate", mx, 2);
    end

    // R8 update source
    do_reset(); wr(1, 9);
    wr(0, 32'h04);
    wr(3, 32'h1); chk("R8 sw counter-only", int'(upd_req), 0);
    pulse_slave(); chk("R8 slave counter-only", int'(upd_req), 0);
    wr(0, 32'h00);
    wr(3, 32'h1); chk("R8 sw any", int'(upd_req), 1);
    pulse_slave(); chk("R8 slave any", int'(upd_req), 1);
    wr(0, 32'h02);
    wr(3, 32'h1); chk("R7 sw blocked", int'(upd_req), 0);

    // R9 one-shot
    do_reset(); wr(1, 4); wr(0, 32'h09);
    repeat (5) @(negedge clk);
    chk("R9 req", int'(upd_req), 1);
    chk("R9 cnt", int'(cnt_val), 0);
    repeat (3) @(negedge clk);
    chk("R9 held", int'(cnt_val), 0);
    rd(0, rv); chk("R9 run cleared", int'(rv[0]), 0);

    // R12 forced reinit
    do_reset(); wr(1, 9); wr(0, 32'h01);
    repeat (5) @(negedge clk);
    wr(3, 32'h1); chk("R12 up to zero", int'(cnt_val), 0);
    wr(0, 32'h91); wr(1, 7);
    wr(3, 32'h1); chk("R12 down to limit", int'(cnt_val), 7);
    @(negedge clk); chk("R12 down step", int'(cnt_val), 6);

    // R11 dead-time enable ratio
    for (int code = 0; code < 4; code++) begin
      int ones;
      do_reset(); wr(0, code << 8);
      ones = 0;
      for (int k = 0; k < 16; k++) begin
        if (dts_en) ones++;
        @(negedge clk);
      end
      chk("R11 ratio", ones, (code == 0) ? 16 : (code == 1) ? 8 : 4);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule